// File: doc/BRIEF.md
# Latched Multi-Select Host Bus Interface

This block sits between a host processor bus and the eight internal registers of a peripheral. It decides whether the peripheral is being addressed by combining three chip selects of mixed polarity. It also turns read and write strobes, each available in an active-high and an active-low form, into single-cycle register enables that are synchronous to the system clock. The output is the decoded register index plus an output enable for the shared 8-bit data bus.

All host inputs pass through a synchronizer. A read or write enable fires once, on the leading edge of the combined strobe. An address strobe input selects how the register address and the chip selects are taken. While the address strobe is low, they follow the bus. A rising edge on the address strobe freezes them for the rest of the access, which supports hosts that multiplex address and data. The register contents live outside this block.

Top module: `hostbus_front`

## Requirements
- R1: The block acts on a strobe only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0 at once. With any other combination, no enable fires and the bus stays undriven.
- R2: A read is requested when `rd_hi`=1 or `rd_lo_n`=0. Either form alone produces a read.
- R3: A write is requested when `wr_hi`=1 or `wr_lo_n`=0. Either form alone produces a write. The byte on `bus_data` goes out on `reg_wdata`.
- R4: Each assertion of the combined read or write strobe gives exactly one single-cycle `rd_en` or `wr_en` pulse, however long the strobe is held.
- R5: While `addr_strobe` stays low, `reg_idx` follows `reg_addr` after the synchronizer delay, and the selects are taken live.
- R6: A rising edge on `addr_strobe` captures `reg_addr` and the three selects. Later changes on those inputs are ignored while `addr_strobe` stays high.
- R7: `bus_data` carries `reg_rdata`, bit 0 least significant, only while a selected read is in progress (`bus_oe`=1). Otherwise it is high impedance.
- R8: A read and a write requested in the same cycle produce no enable and raise `proto_err`.
- R9: After reset, `rd_en`, `wr_en`, `bus_oe` and `proto_err` are 0, and `reg_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Register address from the host |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_hi | input | 1 | Read strobe, active high |
| rd_lo_n | input | 1 | Read strobe, active low |
| wr_hi | input | 1 | Write strobe, active high |
| wr_lo_n | input | 1 | Write strobe, active low |
| addr_strobe | input | 1 | Rising edge latches address and selects |
| bus_data | inout | DATA_W | Bidirectional host data bus |
| reg_rdata | input | DATA_W | Read data from the register file |
| reg_wdata | output | DATA_W | Write data to the register file |
| reg_idx | output | ADDR_W | Decoded register index |
| rd_en | output | 1 | One-cycle register read enable |
| wr_en | output | 1 | One-cycle register write enable |
| bus_oe | output | 1 | Data bus output enable |
| proto_err | output | 1 | Read and write requested together |

## Verification
The bench uses the default parameters: a 3-bit address, an 8-bit bus and a two-stage synchronizer. With these values, every one of the eight register indices can be reached, and the whole select truth table fits into a handful of directed accesses. A model register file behind the block lets data written through one strobe polarity be read back through the other. It also shows that a latched access lands at the captured index and not at the address on the bus at strobe time.

// File: rtl/hostbus_front.sv
module hostbus_front #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              rd_hi,
  input  logic              rd_lo_n,
  input  logic              wr_hi,
  input  logic              wr_lo_n,
  input  logic              addr_strobe,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_idx,
  output logic              rd_en,
  output logic              wr_en,
  output logic              bus_oe,
  output logic              proto_err
);
  localparam int IN_W = ADDR_W + 6;
  localparam int SEL0 = ADDR_W;
  localparam int RDB  = ADDR_W + 3;
  localparam int WRB  = ADDR_W + 4;
  localparam int ASB  = ADDR_W + 5;

  logic [IN_W-1:0] raw;
  logic [IN_W-1:0] sync_q [SYNC_N];
  logic [IN_W-1:0] s;

  assign raw = {addr_strobe, (wr_hi | ~wr_lo_n), (rd_hi | ~rd_lo_n),
                ~sel_c_n, sel_b, sel_a, reg_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_N-1];

  logic [ADDR_W-1:0] live_addr, lat_addr, eff_addr;
  logic [2:0]        live_sel, lat_sel, eff_sel;
  logic              rd_l, wr_l, as_l;
  logic              rd_d, wr_d, as_d;
  logic              as_rise, rd_rise, wr_rise, sel_eff;

  assign live_addr = s[ADDR_W-1:0];
  assign live_sel  = s[SEL0+2:SEL0];
  assign rd_l      = s[RDB];
  assign wr_l      = s[WRB];
  assign as_l      = s[ASB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d     <= 1'b0;
      wr_d     <= 1'b0;
      as_d     <= 1'b0;
      lat_addr <= '0;
      lat_sel  <= '0;
    end else begin
      rd_d <= rd_l;
      wr_d <= wr_l;
      as_d <= as_l;
      if (as_rise) begin
        lat_addr <= live_addr;
        lat_sel  <= live_sel;
      end
    end
  end

  assign as_rise  = as_l & ~as_d;
  assign rd_rise  = rd_l & ~rd_d;
  assign wr_rise  = wr_l & ~wr_d;

  assign eff_addr = as_d ? lat_addr : live_addr;
  assign eff_sel  = as_d ? lat_sel  : live_sel;
  assign sel_eff  = &eff_sel;

  assign reg_idx   = eff_addr;
  assign proto_err = rd_l & wr_l;
  assign rd_en     = rd_rise & ~wr_l & sel_eff;
  assign wr_en     = wr_rise & ~rd_l & sel_eff;
  assign bus_oe    = rd_l & ~wr_l & sel_eff;

  assign bus_data  = bus_oe ? reg_rdata : {DATA_W{1'bz}};
  assign reg_wdata = bus_data;

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_l) |=> (lat_addr == $past(live_addr))); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (as_l && as_d) |=> $stable(lat_addr) && $stable(lat_sel)); // R6
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_l |-> !bus_oe); // R7
  AST_CONFLICT_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !(rd_en || wr_en || bus_oe)); // R8
  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_en, wr_en}) <= 1); // R8
endmodule

// File: tb/hostbus_front_test.sv
`timescale 1ns/1ps
module hostbus_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] reg_addr = '0;
  logic sel_a = 1'b0, sel_b = 1'b0, sel_c_n = 1'b1;
  logic rd_hi = 1'b0, rd_lo_n = 1'b1, wr_hi = 1'b0, wr_lo_n = 1'b1;
  logic addr_strobe = 1'b0;
  logic host_drv = 1'b0;
  logic [7:0] host_val = '0;
  wire  [7:0] bus_data;
  logic [7:0] reg_rdata, reg_wdata;
  logic [2:0] reg_idx;
  logic rd_en, wr_en, bus_oe, proto_err;

  assign bus_data = host_drv ? host_val : 8'hzz;

  hostbus_front uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .rd_hi(rd_hi), .rd_lo_n(rd_lo_n), .wr_hi(wr_hi), .wr_lo_n(wr_lo_n),
    .addr_strobe(addr_strobe), .bus_data(bus_data),
    .reg_rdata(reg_rdata), .reg_wdata(reg_wdata), .reg_idx(reg_idx),
    .rd_en(rd_en), .wr_en(wr_en), .bus_oe(bus_oe), .proto_err(proto_err)
  );

  logic [7:0] rf [8];
  assign reg_rdata = rf[reg_idx];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[reg_idx] <= reg_wdata;
    end
  end

  int n_rd, n_wr, n_err;
  logic [2:0] wr_idx;
  logic [7:0] rd_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin n_rd++; rd_val = bus_data; end
      if (wr_en) begin n_wr++; wr_idx = reg_idx; end
      if (proto_err) n_err++;
    end
  end

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    n_rd = 0; n_wr = 0; n_err = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel = {sel_a, sel_b, sel_c_n}; hi picks the active-high strobe
  task automatic access(input bit wr, input bit hi, input logic [2:0] a,
                        input logic [7:0] d, input logic [2:0] sel);
    @(negedge clk);
    reg_addr = a; {sel_a, sel_b, sel_c_n} = sel;
    host_drv = wr; host_val = d;
    if (wr) begin if (hi) wr_hi = 1'b1; else wr_lo_n = 1'b0; end
    else    begin if (hi) rd_hi = 1'b1; else rd_lo_n = 1'b0; end
    idle(6);
    wr_hi = 1'b0; wr_lo_n = 1'b1; rd_hi = 1'b0; rd_lo_n = 1'b1;
    idle(4);
    host_drv = 1'b0; {sel_a, sel_b, sel_c_n} = 3'b001;
    idle(2);
  endtask

  task automatic t_reset();
    check(!rd_en && !wr_en, "R9 enables", {rd_en, wr_en}, 0);
    check(!bus_oe && !proto_err, "R9 oe/err", {bus_oe, proto_err}, 0);
    check(reg_idx == 3'd0, "R9 idx", reg_idx, 0);
  endtask

  task automatic t_write_read();
    clr(); access(1'b1, 1'b1, 3'd3, 8'hA5, 3'b110);
    check(n_wr == 1 && n_rd == 0, "R3 R4 wr_hi pulse", n_wr, 1);
    check(wr_idx == 3'd3, "R3 wr index", wr_idx, 3);
    clr(); access(1'b0, 1'b0, 3'd3, 8'h00, 3'b110);
    check(n_rd == 1 && n_wr == 0, "R2 R4 rd_lo_n pulse", n_rd, 1);
    check(rd_val == 8'hA5, "R7 read data", rd_val, 8'hA5);
    clr(); access(1'b1, 1'b0, 3'd6, 8'h3C, 3'b110);
    check(n_wr == 1, "R3 wr_lo_n pulse", n_wr, 1);
    clr(); access(1'b0, 1'b1, 3'd6, 8'h00, 3'b110);
    check(n_rd == 1 && rd_val == 8'h3C, "R2 rd_hi read", rd_val, 8'h3C);
    clr(); access(1'b1, 1'b1, 3'd0, 8'h01, 3'b110);
    access(1'b0, 1'b1, 3'd0, 8'h00, 3'b110);
    check(rd_val == 8'h01, "R7 bit0 order", rd_val, 1);
    check(!bus_oe, "R7 oe idle", bus_oe, 0);
  endtask

  task automatic t_select();
    logic [2:0] bad [3];
    bad[0] = 3'b010; bad[1] = 3'b100; bad[2] = 3'b111;
    for (int i = 0; i < 3; i++) begin
      clr(); access(1'b1, 1'b1, 3'd3, 8'hEE, bad[i]);
      check(n_wr == 0, "R1 deselected write", n_wr, 0);
      clr(); access(1'b0, 1'b1, 3'd3, 8'h00, bad[i]);
      check(n_rd == 0, "R1 deselected read", n_rd, 0);
    end
    clr(); access(1'b0, 1'b0, 3'd3, 8'h00, 3'b110);
    check(rd_val == 8'hA5, "R1 reg unchanged", rd_val, 8'hA5);
  endtask

  task automatic t_transparent();
    @(negedge clk); reg_addr = 3'd7; idle(3);
    check(reg_idx == 3'd7, "R5 follow 7", reg_idx, 7);
    reg_addr = 3'd2; idle(3);
    check(reg_idx == 3'd2, "R5 follow 2", reg_idx, 2);
  endtask

  task automatic t_latched();
    clr();
    @(negedge clk); reg_addr = 3'd5; {sel_a, sel_b, sel_c_n} = 3'b110;
    idle(1); addr_strobe = 1'b1; idle(4);
    reg_addr = 3'd2; {sel_a, sel_b, sel_c_n} = 3'b001;
    host_drv = 1'b1; host_val = 8'h77; idle(3);
    check(reg_idx == 3'd5, "R6 idx held", reg_idx, 5);
    wr_hi = 1'b1; idle(6); wr_hi = 1'b0; idle(4);
    check(n_wr == 1 && wr_idx == 3'd5, "R6 latched write", wr_idx, 5);
    host_drv = 1'b0; addr_strobe = 1'b0; idle(4);
    clr(); access(1'b0, 1'b1, 3'd5, 8'h00, 3'b110);
    check(rd_val == 8'h77, "R6 data at latched", rd_val, 8'h77);
    clr(); access(1'b0, 1'b1, 3'd2, 8'h00, 3'b110);
    check(rd_val == 8'h00, "R6 live addr ignored", rd_val, 0);
  endtask

  task automatic t_conflict();
    clr();
    @(negedge clk); reg_addr = 3'd4; {sel_a, sel_b, sel_c_n} = 3'b110;
    host_drv = 1'b1; host_val = 8'h99;
    rd_hi = 1'b1; wr_hi = 1'b1; idle(6);
    rd_hi = 1'b0; wr_hi = 1'b0; idle(4); host_drv = 1'b0;
    check(n_rd == 0 && n_wr == 0, "R8 no op", n_rd + n_wr, 0);
    check(n_err > 0, "R8 proto_err", n_err, 1);
    clr(); access(1'b0, 1'b1, 3'd4, 8'h00, 3'b110);
    check(rd_val == 8'h00, "R8 reg untouched", rd_val, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_write_read();
    t_select();
    t_transparent();
    t_latched();
    t_conflict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule